// File: doc/BRIEF.md
# Addressable Bit Latch with Demultiplexer

This block keeps a small bank of single-bit storage cells, each driving its own output bit. A binary select input picks one cell, and a single data bit is written into it. Two active-low controls, a clear and a write strobe, pick one of four operating modes:

- clear every cell;
- decode, where the selected cell takes the data and every other cell is forced low;
- addressed write, where only the selected cell changes;
- hold.

Everything is sampled on the rising clock edge, and the outputs are registered. The block can load a byte one bit at a time by stepping the select. It can also act as an active-high one-of-N decoder when the data input is tied high.

Top module: `addr_bit_latch`

## Requirements
- R1: The select value n (binary, unsigned) addresses output bit n, so select all zeros addresses bit 0. With the default 3-bit select there are 8 output bits.
- R2: When `clr_n`=0 and `wr_n`=1 are sampled at a rising edge, all output bits are 0 after that edge, whatever `sel` and `din` are.
- R3: When `clr_n`=0 and `wr_n`=0 are sampled, after that edge output bit `sel` equals `din` and every other bit is 0.
- R4: When `clr_n`=1 and `wr_n`=0 are sampled, after that edge output bit `sel` equals `din` and the other bits keep their previous values.
- R5: When `clr_n`=1 and `wr_n`=1 are sampled, the outputs do not change, whatever `sel` and `din` are.
- R6: All inputs are sampled only at the rising clock edge. The mode in force at an edge is set by the `clr_n` and `wr_n` values sampled at that same edge. Outputs change only at rising edges.
- R7: From power-up, before the first clock edge, all output bits are 0.
- R8: When `wr_n` stays low while `sel` changes on every edge, each addressed bit is loaded in turn. After `wr_n` returns high, each bit holds the last `din` sampled for it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| clr_n | input | 1 | Active-low clear / decode control |
| wr_n | input | 1 | Active-low write strobe |
| din | input | 1 | Data bit to store |
| sel | input | SEL_W (3) | Binary bit select |
| q | output | 2**SEL_W (8) | Stored bits, one per output |

## Verification
On every cycle, the assertions check the four mode rules from the ports. Clear leaves all zeros. Decode leaves only the addressed bit, equal to the data. An addressed write changes no bit other than the selected one. Hold keeps the outputs stable. They also check that the select decode is one-hot. The assertions cannot show the power-up value, or that a byte loaded bit by bit survives later hold cycles. Only the bench's scenarios show these: a serial load with a changing select followed by holds, and a sweep of every mode over every address and data value from several preloaded patterns.

// File: rtl/abl_pkg.sv
package abl_pkg;
  typedef enum logic [1:0] {
    MODE_CLEAR  = 2'd0,
    MODE_DECODE = 2'd1,
    MODE_WRITE  = 2'd2,
    MODE_HOLD   = 2'd3
  } abl_mode_e;
endpackage

// File: rtl/abl_mode_dec.sv
module abl_mode_dec
  import abl_pkg::*;
(
  input  logic      clr_n,
  input  logic      wr_n,
  output abl_mode_e mode
);
  always_comb begin
    unique case ({clr_n, wr_n})
      2'b01:   mode = MODE_CLEAR;
      2'b00:   mode = MODE_DECODE;
      2'b10:   mode = MODE_WRITE;
      default: mode = MODE_HOLD;
    endcase
  end
endmodule

// File: rtl/abl_onehot.sv
module abl_onehot #(
  parameter int SEL_W = 3,
  localparam int NUM_BITS = 1 << SEL_W
) (
  input  logic [SEL_W-1:0]    sel,
  output logic [NUM_BITS-1:0] hit
);
  for (genvar i = 0; i < NUM_BITS; i++) begin : g_hit
    assign hit[i] = (sel == SEL_W'(i));
  end

  // R1: exactly one cell addressed for any select value
  always_comb begin
    a_r1_onehot_select: assert ($countones(hit) == 1)
      else $error("select decode not one-hot");
  end
endmodule

// File: rtl/abl_cell.sv
module abl_cell
  import abl_pkg::*;
(
  input  logic      clk,
  input  abl_mode_e mode,
  input  logic      hit,
  input  logic      din,
  output logic      q
);
  logic q_r = 1'b0;
  logic q_nxt;

  always_comb begin
    unique case (mode)
      MODE_CLEAR:  q_nxt = 1'b0;
      MODE_DECODE: q_nxt = hit ? din : 1'b0;
      MODE_WRITE:  q_nxt = hit ? din : q_r;
      default:     q_nxt = q_r;
    endcase
  end

  always_ff @(posedge clk) q_r <= q_nxt;

  assign q = q_r;
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import abl_pkg::*;
#(
  parameter int SEL_W = 3,
  localparam int NUM_BITS = 1 << SEL_W
) (
  input  logic                clk,
  input  logic                clr_n,
  input  logic                wr_n,
  input  logic                din,
  input  logic [SEL_W-1:0]    sel,
  output logic [NUM_BITS-1:0] q
);
  abl_mode_e           mode;
  logic [NUM_BITS-1:0] hit;

  abl_mode_dec u_mode (
    .clr_n (clr_n),
    .wr_n  (wr_n),
    .mode  (mode)
  );

  abl_onehot #(.SEL_W(SEL_W)) u_sel (
    .sel (sel),
    .hit (hit)
  );

  for (genvar i = 0; i < NUM_BITS; i++) begin : g_cell
    abl_cell u_cell (
      .clk  (clk),
      .mode (mode),
      .hit  (hit[i]),
      .din  (din),
      .q    (q[i])
    );
  end

  // Assertion arming: no check until one edge has passed
  logic armed = 1'b0;
  always_ff @(posedge clk) armed <= 1'b1;

  a_r2_clear_all: assert property (@(posedge clk) disable iff (!armed)
    (!clr_n && wr_n) |=> (q == '0));

  a_r3_decode: assert property (@(posedge clk) disable iff (!armed)
    (!clr_n && !wr_n) |=>
      (q == (NUM_BITS'($past(din)) << $past(sel))));

  a_r4_write_target: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !wr_n) |=> (q[$past(sel)] == $past(din)));

  a_r4_write_others: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && !wr_n) |=>
      (((q ^ $past(q)) & ~(NUM_BITS'(1) << $past(sel))) == '0));

  a_r5_hold: assert property (@(posedge clk) disable iff (!armed)
    (clr_n && wr_n) |=> $stable(q));
endmodule

// File: tb/addr_bit_latch_bench.sv
`timescale 1ns/1ps
module addr_bit_latch_bench;
  localparam int SEL_W = 3;
  localparam int NB = 1 << SEL_W;

  logic clk = 1'b0;
  logic clr_n = 1'b1, wr_n = 1'b1, din = 1'b0;
  logic [SEL_W-1:0] sel = '0;
  logic [NB-1:0] q;
  logic [NB-1:0] model = '0;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  addr_bit_latch #(.SEL_W(SEL_W)) u_addr_bit_latch (
    .clk(clk), .clr_n(clr_n), .wr_n(wr_n), .din(din), .sel(sel), .q(q)
  );

  task automatic check(input string req, input logic [NB-1:0] exp);
    checks++;
    if (q !== exp) begin
      errors++;
      $display("FAIL %s: q=%h expected %h", req, q, exp);
    end
  endtask

  // Drive at falling edge, update model at rising edge, check at next falling edge
  task automatic step(input string req, input logic c, input logic w,
                      input logic d, input logic [SEL_W-1:0] a);
    clr_n = c; wr_n = w; din = d; sel = a;
    @(posedge clk);
    case ({c, w})
      2'b01: model = '0;
      2'b00: model = NB'(d) << a;
      2'b10: model[a] = d;
      default: ;
    endcase
    @(negedge clk);
    check(req, model);
  endtask

  task automatic serial_load(input string req, input logic [NB-1:0] pat);
    for (int i = 0; i < NB; i++) step(req, 1'b1, 1'b0, pat[i], SEL_W'(i));
  endtask

  initial begin
    logic [NB-1:0] pats [4];
    pats[0] = 8'hA5; pats[1] = 8'h3C; pats[2] = 8'hFF; pats[3] = 8'h00;
    #1;
    check("R7", '0);
    @(negedge clk);
    check("R7", '0);
    // R8: serial load with address stepping every edge, then holds
    serial_load("R8", 8'h96);
    check("R8", 8'h96);
    for (int i = 0; i < 4; i++) step("R8", 1'b1, 1'b1, ~din, SEL_W'(i * 3));
    check("R8", 8'h96);
    // R1: single writes to each address from zero
    step("R2", 1'b0, 1'b1, 1'b1, 3'd5);
    for (int a = 0; a < NB; a++) step("R1", 1'b1, 1'b0, 1'b1, SEL_W'(a));
    // Sweep every mode, address and data over several preloaded patterns
    for (int p = 0; p < 4; p++) begin
      for (int m = 0; m < 4; m++) begin
        for (int a = 0; a < NB; a++) begin
          for (int d = 0; d < 2; d++) begin
            serial_load("R4", pats[p]);
            case (m)
              0: step("R2", 1'b0, 1'b1, d[0], SEL_W'(a));
              1: step("R3", 1'b0, 1'b0, d[0], SEL_W'(a));
              2: step("R4", 1'b1, 1'b0, d[0], SEL_W'(a));
              default: step("R5", 1'b1, 1'b1, d[0], SEL_W'(a));
            endcase
          end
        end
      end
    end
    // R6: mode change takes effect on the same edge it is sampled
    serial_load("R6", 8'hF0);
    step("R6", 1'b0, 1'b0, 1'b1, 3'd2);
    step("R6", 1'b1, 1'b0, 1'b1, 3'd7);
    step("R6", 1'b0, 1'b1, 1'b1, 3'd7);
    // R3: decoder sweep with data high
    for (int a = 0; a < NB; a++) step("R3", 1'b0, 1'b0, 1'b1, SEL_W'(a));
    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule